// File: doc/BRIEF.md
# FDDI Frame Copy/Discard Filter

This block watches the byte stream of an incoming FDDI frame and decides, early in the frame, whether the MAC side should copy it or let it pass. It reads the Frame Control byte, the destination address and the first byte of the source address. It uses a per-frame lookup result (hit or miss of the destination in an external address table) and a small set of configuration inputs. Frames that carry a routing information field are handed to a separate routing filter rather than judged here, unless the block is set to transparent-only operation.

A frame starts with `sof` and `byte_vld` both high on the Frame Control byte. The next six valid bytes are the destination address, most significant byte first, and the byte after those opens the source address. Tokens, void frames, station-management frames and frames with short addresses get a silent decision: the result is valid but every flag is low. The other classes (LLC, MAC, Reserved) take a fixed copy, a fixed discard, or destination filtering, as their two-bit type setting selects. Filtering is positive or negative. In negative mode, broadcast, functional and group destinations can each be dropped on their own.

The result is registered. `dec_vld` rises one clock after the last input the decision needs has been sampled, and the result holds until the next start of frame.

Top module: `fddi_copy_filter`

## Requirements
- R1: After reset, `dec_vld`, `copy`, `da_match` and `to_route` are all low.
- R2: A Frame Control byte of 0x80 or 0xC0 (a token) gives `dec_vld` high one clock after the FC byte, with `copy`, `da_match` and `to_route` low.
- R3: Any frame whose FC bits [5:4] are 00 (void, SMT, token) or whose FC bit 6 is 0 (16-bit addresses) gets the same silent decision one clock after the FC byte, whatever the lookup result.
- R4: For a frame with 48-bit addresses, bit 7 of the first source-address byte (the eighth byte of the frame) is the routing indicator. When it is set and `cfg_transp_only` is low, the decision comes one clock after that byte, with `to_route` high, `copy` and `da_match` low, and no lookup needed.
- R5: With `cfg_transp_only` high, a frame whose routing indicator is set is judged like any other frame and `to_route` stays low.
- R6: FC bits [5:4] = 01, 10 and 11 select LLC, MAC and Reserved, using `cfg_type_sel` bits [1:0], [3:2] and [5:4]. A setting of 01 copies, 10 or 11 discards, and in both cases the decision comes one clock after the first source byte with `da_match` low. A setting of 00 selects destination filtering.
- R7: In positive filtering (`cfg_neg_filt` low), `copy` and `da_match` both equal the lookup hit.
- R8: In negative filtering, `da_match` equals the lookup hit, and `copy` is high only on a miss whose destination class is not dropped by its enable.
- R9: The destination class comes from bit 7 of the first destination byte (1 = group). All-ones is broadcast. A group address that is not broadcast and whose top PFX_W bits equal `cfg_func_pfx` is functional. Any other group address is plain group. Broadcast takes precedence over functional, and functional over group. Individual destinations are never dropped.
- R10: A filtered decision rises one clock after the later of the first source byte and the first lookup strobe that follows the FC cycle. A strobe in the FC cycle, and any strobe after the first, is ignored.
- R11: Once `dec_vld` is high, the outputs hold until the next start of frame, whatever bytes or strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start of frame, high with the FC byte |
| byte_vld | input | 1 | Byte on `byte_dat` is valid |
| byte_dat | input | 8 | Frame byte |
| lkup_vld | input | 1 | Destination lookup result strobe |
| lkup_hit | input | 1 | Destination found in the address table |
| cfg_transp_only | input | 1 | Judge routed frames here too |
| cfg_neg_filt | input | 1 | 1 = negative filtering, 0 = positive |
| cfg_type_sel | input | 6 | Two-bit action for LLC, MAC and Reserved |
| cfg_drop_bcast | input | 1 | Negative mode: drop broadcast destinations |
| cfg_drop_func | input | 1 | Negative mode: drop functional destinations |
| cfg_drop_group | input | 1 | Negative mode: drop plain group destinations |
| cfg_func_pfx | input | PFX_W | Functional address prefix |
| dec_vld | output | 1 | Decision valid |
| copy | output | 1 | Copy the frame |
| da_match | output | 1 | Destination matched in the table |
| to_route | output | 1 | Frame handed to the routing filter |

## Verification
The bench sweeps all 256 Frame Control values, so a decoder that takes a void or short-address frame for a filtered class would report a late or non-silent decision. Lookups land before, on and after the first source byte, and a few frames carry a strobe in the FC cycle or a second strobe. An off-by-one in the join of those two events shows up as `dec_vld` rising a cycle early or late, and taking the wrong strobe flips `copy`. Every destination class is crossed with every drop-enable pattern and with hit and miss. This exposes a broken precedence (a broadcast dropped by the group enable) and a wrong prefix compare (a near-functional address treated as functional). Routed frames are run with transparent-only both off and on, to catch a block that still filters them or never stops handing them off.

// File: rtl/fddi_flt_pkg.sv
package fddi_flt_pkg;

    // Frame class decoded from the Frame Control byte
    typedef enum logic [2:0] {
        FT_TOKEN,
        FT_VOID,
        FT_SMT,
        FT_LLC,
        FT_MAC,
        FT_RSV
    } ftype_e;

endpackage

// File: rtl/fddi_fc_decode.sv
module fddi_fc_decode
    import fddi_flt_pkg::*;
(
    input  logic [7:0] fc,
    output ftype_e     ftype,
    output logic       long_addr
);

    logic [1:0] ff;
    logic [3:0] zz;

    always_comb begin
        ff        = fc[5:4];
        zz        = fc[3:0];
        long_addr = fc[6];
        unique case (ff)
            2'b00:   ftype = (zz != 4'h0) ? FT_SMT : (fc[7] ? FT_TOKEN : FT_VOID);
            2'b01:   ftype = FT_LLC;
            2'b10:   ftype = FT_MAC;
            default: ftype = FT_RSV;
        endcase
    end

endmodule

// File: rtl/fddi_da_class.sv
module fddi_da_class #(
    parameter int DA_W  = 48,
    parameter int PFX_W = 16
) (
    input  logic [DA_W-1:0]  da,
    input  logic [PFX_W-1:0] func_pfx,
    output logic             is_grp,
    output logic             is_bcast,
    output logic             is_func
);

    always_comb begin
        is_grp   = da[DA_W-1];
        is_bcast = &da;
        is_func  = is_grp && !is_bcast && (da[DA_W-1 -: PFX_W] == func_pfx);
    end

endmodule

// File: rtl/fddi_copy_filter.sv
module fddi_copy_filter
    import fddi_flt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int PFX_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic [7:0]       byte_dat,
    input  logic             lkup_vld,
    input  logic             lkup_hit,
    input  logic             cfg_transp_only,
    input  logic             cfg_neg_filt,
    input  logic [5:0]       cfg_type_sel,
    input  logic             cfg_drop_bcast,
    input  logic             cfg_drop_func,
    input  logic             cfg_drop_group,
    input  logic [PFX_W-1:0] cfg_func_pfx,
    output logic             dec_vld,
    output logic             copy,
    output logic             da_match,
    output logic             to_route
);

    localparam int DA_W   = 8 * ADDR_BYTES;
    localparam int SA_IDX = ADDR_BYTES + 1;
    localparam int CNT_W  = $clog2(SA_IDX + 2);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       fc;
        logic [DA_W-1:0]  da;
        logic             rii_got;
        logic             rii;
        logic             lk_got;
        logic             lk_hit;
        logic             done;
        logic             copy;
        logic             match;
        logic             route;
    } st_t;

    st_t st_d, st_q;

    // Frame Control decode works on the byte in flight during the FC cycle
    logic [7:0] fc_e;
    ftype_e     ftype;
    logic       long_addr;

    fddi_fc_decode u_fc (
        .fc        (fc_e),
        .ftype     (ftype),
        .long_addr (long_addr)
    );

    logic is_grp, is_bcast, is_func;

    fddi_da_class #(.DA_W(DA_W), .PFX_W(PFX_W)) u_da (
        .da       (st_q.da),
        .func_pfx (cfg_func_pfx),
        .is_grp   (is_grp),
        .is_bcast (is_bcast),
        .is_func  (is_func)
    );

    logic       first, in_body, active, done_e, lk_got_e;
    logic       sa_now, rii_have, rii_v, lk_now, lk_have, hit_v;
    logic       silent, drop;
    logic [1:0] sel;

    always_comb begin
        first    = sof && byte_vld;
        in_body  = !first && st_q.busy;
        active   = first || st_q.busy;
        fc_e     = first ? byte_dat : st_q.fc;
        done_e   = first ? 1'b0 : st_q.done;
        lk_got_e = first ? 1'b0 : st_q.lk_got;

        sa_now   = in_body && byte_vld && (st_q.cnt == CNT_W'(SA_IDX));
        rii_have = in_body && (st_q.rii_got || sa_now);
        rii_v    = st_q.rii_got ? st_q.rii : byte_dat[7];
        lk_now   = in_body && lkup_vld && !st_q.lk_got;
        lk_have  = lk_got_e || lk_now;
        hit_v    = lk_got_e ? st_q.lk_hit : lkup_hit;

        silent   = !long_addr || (ftype == FT_TOKEN) || (ftype == FT_VOID) || (ftype == FT_SMT);

        unique case (ftype)
            FT_LLC:  sel = cfg_type_sel[1:0];
            FT_MAC:  sel = cfg_type_sel[3:2];
            FT_RSV:  sel = cfg_type_sel[5:4];
            default: sel = 2'b10;
        endcase

        if (is_bcast)      drop = cfg_drop_bcast;
        else if (is_func)  drop = cfg_drop_func;
        else if (is_grp)   drop = cfg_drop_group;
        else               drop = 1'b0;

        st_d      = st_q;
        st_d.busy = active;
        st_d.done = done_e;

        if (first) begin
            st_d.fc      = byte_dat;
            st_d.cnt     = CNT_W'(1);
            st_d.rii_got = 1'b0;
            st_d.rii     = 1'b0;
            st_d.lk_got  = 1'b0;
            st_d.lk_hit  = 1'b0;
            st_d.copy    = 1'b0;
            st_d.match   = 1'b0;
            st_d.route   = 1'b0;
        end else if (in_body && byte_vld) begin
            if (st_q.cnt >= CNT_W'(1) && st_q.cnt <= CNT_W'(ADDR_BYTES))
                st_d.da = {st_q.da[DA_W-9:0], byte_dat};
            if (sa_now) begin
                st_d.rii_got = 1'b1;
                st_d.rii     = byte_dat[7];
            end
            if (st_q.cnt <= CNT_W'(SA_IDX))
                st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (lk_now && !st_q.done) begin
            st_d.lk_got = 1'b1;
            st_d.lk_hit = lkup_hit;
        end

        // Resolve the decision once; it then holds until the next frame
        if (active && !done_e) begin
            if (silent) begin
                st_d.done = 1'b1;
            end else if (rii_have) begin
                if (rii_v && !cfg_transp_only) begin
                    st_d.done  = 1'b1;
                    st_d.route = 1'b1;
                end else if (sel == 2'b01) begin
                    st_d.done = 1'b1;
                    st_d.copy = 1'b1;
                end else if (sel[1]) begin
                    st_d.done = 1'b1;
                end else if (lk_have) begin
                    st_d.done  = 1'b1;
                    st_d.match = hit_v;
                    st_d.copy  = cfg_neg_filt ? (!hit_v && !drop) : hit_v;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_vld  = st_q.done;
    assign copy     = st_q.copy;
    assign da_match = st_q.match;
    assign to_route = st_q.route;

endmodule

// File: rtl/fddi_copy_filter_chk.sv
module fddi_copy_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sof,
    input logic       byte_vld,
    input logic [7:0] byte_dat,
    input logic       cfg_neg_filt,
    input logic       dec_vld,
    input logic       copy,
    input logic       da_match,
    input logic       to_route
);

    assert_token_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && byte_vld && (byte_dat == 8'h80 || byte_dat == 8'hC0))
        |=> (dec_vld && !copy && !da_match && !to_route));

    assert_silent_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && byte_vld && (byte_dat[5:4] == 2'b00 || !byte_dat[6]))
        |=> (dec_vld && !copy && !da_match && !to_route));

    assert_route_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && to_route) |-> (!copy && !da_match));

    assert_pos_hit_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !sof && !cfg_neg_filt && da_match) |-> copy);

    assert_neg_hit_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !sof && cfg_neg_filt && da_match) |-> !copy);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && !(sof && byte_vld))
        |=> (dec_vld && $stable(copy) && $stable(da_match) && $stable(to_route)));

endmodule

bind fddi_copy_filter fddi_copy_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (sof),
    .byte_vld     (byte_vld),
    .byte_dat     (byte_dat),
    .cfg_neg_filt (cfg_neg_filt),
    .dec_vld      (dec_vld),
    .copy         (copy),
    .da_match     (da_match),
    .to_route     (to_route)
);

// File: tb/fddi_copy_filter_tb_top.sv
module fddi_copy_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, byte_vld = 1'b0;
    logic [7:0]  byte_dat = 8'h00;
    logic        lkup_vld = 1'b0, lkup_hit = 1'b0;
    logic        cfg_transp_only = 1'b0, cfg_neg_filt = 1'b0;
    logic [5:0]  cfg_type_sel = 6'h0;
    logic        cfg_drop_bcast = 1'b0, cfg_drop_func = 1'b0, cfg_drop_group = 1'b0;
    logic [15:0] cfg_func_pfx = 16'hC000;
    logic        dec_vld, copy, da_match, to_route;

    // pending configuration, applied in the FC cycle of the next frame
    logic        n_to = 1'b0, n_neg = 1'b0, n_dbc = 1'b0, n_dfn = 1'b0, n_dgr = 1'b0;
    logic [5:0]  n_tsel = 6'h0;

    int errors = 0;
    int checks = 0;

    localparam logic [15:0] PFX = 16'hC000;

    always #4 clk = ~clk;

    fddi_copy_filter dut_i (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .lkup_vld(lkup_vld), .lkup_hit(lkup_hit),
        .cfg_transp_only(cfg_transp_only), .cfg_neg_filt(cfg_neg_filt),
        .cfg_type_sel(cfg_type_sel), .cfg_drop_bcast(cfg_drop_bcast),
        .cfg_drop_func(cfg_drop_func), .cfg_drop_group(cfg_drop_group),
        .cfg_func_pfx(cfg_func_pfx),
        .dec_vld(dec_vld), .copy(copy), .da_match(da_match), .to_route(to_route)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One frame of 13 bytes plus 4 idle cycles. lk_at/lk2_at: cycle index of
    // lookup strobes (-1 = none); the second strobe carries the inverted hit.
    task automatic run_frame(input logic [7:0] fc, input logic [47:0] da,
                             input logic rii, input logic hit,
                             input int lk_at, input int lk2_at);
        int    e_cyc;
        logic  ec, em, er, h, grp, bc, fn, drp;
        logic  [1:0] sel;
        int    le;
        string tag;
        bit    tbad;
        logic  [3:0] first_bad;
        ec = 1'b0; em = 1'b0; er = 1'b0; tbad = 1'b0; first_bad = 4'h0;
        grp = da[47];
        bc  = &da;
        fn  = grp && !bc && (da[47:32] == PFX);
        drp = bc ? n_dbc : (fn ? n_dfn : (grp ? n_dgr : 1'b0));
        if (fc[5:4] == 2'b00 || !fc[6]) begin
            e_cyc = 0;
            tag = (fc == 8'h80 || fc == 8'hC0) ? "R2" : "R3";
        end else if (rii && !n_to) begin
            e_cyc = 7; er = 1'b1; tag = "R4";
        end else begin
            sel = n_tsel[2*(int'(fc[5:4])-1) +: 2];
            if (sel != 2'b00) begin
                e_cyc = 7; ec = (sel == 2'b01); tag = "R6";
            end else begin
                if (lk_at >= 1) begin le = lk_at; h = hit; end
                else begin le = lk2_at; h = !hit; end
                e_cyc = (le > 7) ? le : 7;
                em = h;
                ec = n_neg ? (!h && !drp) : h;
                tag = rii ? "R5" : (n_neg ? "R8" : "R7");
            end
        end
        for (int k = 0; k <= 16; k++) begin
            @(negedge clk);
            if (k == 0) begin
                cfg_transp_only = n_to; cfg_neg_filt = n_neg; cfg_type_sel = n_tsel;
                cfg_drop_bcast = n_dbc; cfg_drop_func = n_dfn; cfg_drop_group = n_dgr;
            end
            sof      = (k == 0);
            byte_vld = (k <= 12);
            if (k == 0)      byte_dat = fc;
            else if (k <= 6) byte_dat = da[47 - 8*(k-1) -: 8];
            else if (k == 7) byte_dat = {rii, 7'h15};
            else             byte_dat = 8'(k * 37);
            lkup_vld = (k == lk_at) || (k == lk2_at);
            lkup_hit = (k == lk_at) ? hit : !hit;
            @(posedge clk);
            #1;
            if (dec_vld !== (k >= e_cyc) && !tbad) begin
                tbad = 1'b1;
                first_bad = 4'(k);
            end
        end
        // R10 / R11: dec_vld rises in the expected cycle and stays high
        check(!tbad, tag, "R10 decision timing (first bad cycle)", first_bad, 4'(e_cyc));
        check({copy, da_match, to_route} === {ec, em, er}, tag, "R11 held copy/match/route",
              {1'b0, copy, da_match, to_route}, {1'b0, ec, em, er});
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [47:0] das [5];
        das[0] = 48'h12_34_56_78_9A_BC;  // individual
        das[1] = 48'h81_22_33_44_55_66;  // plain group
        das[2] = {PFX, 32'h0000_0010};   // functional
        das[3] = 48'hFF_FF_FF_FF_FF_FF;  // broadcast
        das[4] = {16'hC001, 32'h0000_0010}; // near-functional, plain group

        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check({dec_vld, copy, da_match, to_route} === 4'b0000, "R1", "reset outputs",
              {dec_vld, copy, da_match, to_route}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep every FC value: R2 R3 R4 R6 R7 R10
        n_tsel = 6'b10_01_00;
        for (int f = 0; f < 256; f++) begin
            run_frame(8'(f), das[f % 5], f[1], f[2], 1 + (f % 12), -1);
        end

        // Destination classes x drop enables x hit, both filter polarities: R7 R8 R9
        n_tsel = 6'b00_00_00;
        for (int neg = 0; neg < 2; neg++)
            for (int dv = 0; dv < 8; dv++)
                for (int c = 0; c < 5; c++)
                    for (int hv = 0; hv < 2; hv++) begin
                        n_neg = neg[0];
                        n_dbc = dv[0]; n_dfn = dv[1]; n_dgr = dv[2];
                        run_frame(8'h50 + 8'(16 * (c % 3)), das[c], 1'b0, hv[0], 3 + 3*c, -1);
                    end

        // Routed frames with transparent-only off and on: R4 R5
        for (int t = 0; t < 2; t++)
            for (int hv = 0; hv < 2; hv++)
                for (int l = 1; l < 12; l += 3) begin
                    n_to = t[0];
                    run_frame(8'h51, das[hv + 1], 1'b1, hv[0], l, -1);
                end
        n_to = 1'b0;

        // Lookup strobe rules: R10 (FC-cycle strobe ignored, later strobes ignored)
        n_neg = 1'b0;
        run_frame(8'h50, das[0], 1'b0, 1'b1, 0, 9);
        run_frame(8'h50, das[0], 1'b0, 1'b0, 0, 5);
        run_frame(8'h60, das[0], 1'b0, 1'b1, 3, 5);
        run_frame(8'h70, das[0], 1'b0, 1'b0, 7, 10);
        run_frame(8'h50, das[0], 1'b0, 1'b1, 14, 15);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule